// File: doc/BRIEF.md
# Wrap-Event Pointer Separation Tracker

This block sits in the faster clock domain of a circular-queue clock crossing. It does not carry the write pointer across the domain boundary. It takes only the top bit of the write pointer and shifts it through a synchronizer chain. That chain advances only on cycles where the read side is allowed to step, so it runs at the queue's data rate. When the delayed copy of that bit drops from one to zero, the write pointer has wrapped back to entry zero. At that moment the block compares the live read pointer against a programmable target slot.

Each comparison produces a one-cycle valid strobe and a two-bit verdict. The verdict is on target, read pointer ahead, or read pointer behind. A later filter stage averages these verdicts and decides whether to nudge the read pointer. A tracking-enable input lets software-free control logic suppress verdicts entirely, for example while the queue is still being primed.

Top module: `wrap_tracker`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `sample_vld` is 0 and `sample_code` is 2'b00.
- R2: The synchronizer chain moves only on clock edges where `rd_adv` is 1. The value of `wr_msb` sampled at such an edge reaches the evaluation point after SYNC_STAGES (default 8) advancing edges in total, counting the sampling edge.
- R3: A 1-to-0 transition of the sampled write-pointer top bit produces exactly one `sample_vld` pulse, one cycle wide. The pulse is seen in the cycle after the SYNC_STAGES-th advancing edge, counting from the edge that sampled the 0.
- R4: A 0-to-1 transition, or a steady level of the sampled bit, never produces `sample_vld`.
- R5: The comparison uses `rd_ptr` and `sep_target` as seen at the clock edge that raises `sample_vld`. When the two are equal, `sample_code` is 2'b00.
- R6: When (rd_ptr − sep_target) mod 2^PTR_W lies in 1 .. 2^(PTR_W−1)−1, `sample_code` is 2'b01 (read pointer ahead).
- R7: When (rd_ptr − sep_target) mod 2^PTR_W lies in 2^(PTR_W−1) .. 2^PTR_W−1, `sample_code` is 2'b10 (read pointer behind). The half-way distance counts as behind.
- R8: If `track_en` is 0 at the edge where a verdict would be registered, no `sample_vld` is produced and `sample_code` keeps its previous value.
- R9: `sample_code` never takes the value 2'b11, and it changes only on a cycle where `sample_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_adv | input | 1 | Read-advance qualifier; chain shifts on edges where it is 1 |
| wr_msb | input | 1 | Top bit of the write pointer, from the other domain |
| rd_ptr | input | PTR_W | Current read pointer |
| sep_target | input | PTR_W | Desired read pointer position at write wrap |
| track_en | input | 1 | 1 enables verdicts, 0 suppresses them |
| sample_vld | output | 1 | One-cycle strobe marking a new verdict |
| sample_code | output | 2 | Verdict: 00 on target, 01 ahead, 10 behind |

## Verification
A falling top bit is sampled at an advancing edge. The verdict strobe is due one clock after the seventh further advancing edge. With `rd_adv` asserted every P-th cycle, the bench therefore expects it at the falling edge 7P+2 cycles after the stimulus is applied. The bench tallies every strobe in a window past that point and requires exactly one, at exactly that cycle. It also requires none during the rising-edge prefill. The pointer and target values are held steady across the whole window. The verdict is then compared with a modular difference computed in the bench, over all 64 pointer/target pairs and for stall ratios of 1, 2 and 3.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        SEP_ON_TARGET = 2'b00,
        SEP_AHEAD     = 2'b01,
        SEP_BEHIND    = 2'b10
    } sep_code_e;

endpackage

// File: rtl/wt_sync_chain.sv
module wt_sync_chain #(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              din,
    output logic [STAGES-1:0] taps
);
    // bit 0 holds the newest sample, bit STAGES-1 the oldest
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.sh = {st_q.sh[STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps = st_q.sh;

endmodule

// File: rtl/wt_fall_detect.sv
module wt_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic tail,
    input  logic pre_tail,
    output logic evt
);
    typedef struct packed {
        logic evt;
    } fall_st_t;

    fall_st_t st_d, st_q;

    // tail is about to take pre_tail's value on this advancing edge
    always_comb begin
        st_d     = st_q;
        st_d.evt = adv & tail & ~pre_tail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt = st_q.evt;

endmodule

// File: rtl/wt_offset_compare.sv
module wt_offset_compare
    import wt_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             en,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] target,
    output logic             vld,
    output sep_code_e        code
);
    typedef struct packed {
        logic      vld;
        sep_code_e code;
    } cmp_st_t;

    cmp_st_t          st_d, st_q;
    logic [PTR_W-1:0] offset;

    always_comb begin
        offset = rd_ptr - target;
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (evt && en) begin
            st_d.vld = 1'b1;
            if (offset == '0) begin
                st_d.code = SEP_ON_TARGET;
            end else if (offset[PTR_W-1]) begin
                st_d.code = SEP_BEHIND;
            end else begin
                st_d.code = SEP_AHEAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, code: SEP_ON_TARGET};
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign code = st_q.code;

endmodule

// File: rtl/wrap_tracker.sv
module wrap_tracker
    import wt_pkg::*;
#(
    parameter int PTR_W       = 3,
    parameter int SYNC_STAGES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_adv,
    input  logic             wr_msb,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] sep_target,
    input  logic             track_en,
    output logic             sample_vld,
    output logic [1:0]       sample_code
);
    localparam int TAIL_IDX = SYNC_STAGES - 1;
    localparam int PRE_IDX  = SYNC_STAGES - 2;

    logic [SYNC_STAGES-1:0] taps;
    logic                   sync_tail;
    logic                   wrap_evt;
    sep_code_e              code_e;

    wt_sync_chain #(.STAGES(SYNC_STAGES)) chain_i (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (rd_adv),
        .din  (wr_msb),
        .taps (taps)
    );

    assign sync_tail = taps[TAIL_IDX];

    wt_fall_detect fall_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (rd_adv),
        .tail    (sync_tail),
        .pre_tail(taps[PRE_IDX]),
        .evt     (wrap_evt)
    );

    wt_offset_compare #(.PTR_W(PTR_W)) cmp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (wrap_evt),
        .en    (track_en),
        .rd_ptr(rd_ptr),
        .target(sep_target),
        .vld   (sample_vld),
        .code  (code_e)
    );

    assign sample_code = code_e;

endmodule

// File: rtl/wrap_tracker_chk.sv
module wrap_tracker_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_adv,
    input logic             track_en,
    input logic             sync_tail,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] sep_target,
    input logic             sample_vld,
    input logic [1:0]       sample_code
);
    // R9
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_code != 2'b11);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |-> $stable(sample_code));

    // R3
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld);

    // R8
    vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(track_en));

    // R5
    on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && $past(rd_ptr) == $past(sep_target)) |-> sample_code == 2'b00);

    // R2
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_adv |=> $stable(sync_tail));

endmodule

bind wrap_tracker wrap_tracker_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_adv     (rd_adv),
    .track_en   (track_en),
    .sync_tail  (sync_tail),
    .rd_ptr     (rd_ptr),
    .sep_target (sep_target),
    .sample_vld (sample_vld),
    .sample_code(sample_code)
);

// File: tb/wrap_tracker_tb_top.sv
module wrap_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 3;
    localparam int STAGES     = 8;
    localparam int NSLOT      = 1 << PTR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_adv = 1'b0;
    logic             wr_msb = 1'b0;
    logic [PTR_W-1:0] rd_ptr = '0;
    logic [PTR_W-1:0] sep_target = '0;
    logic             track_en = 1'b1;
    logic             sample_vld;
    logic [1:0]       sample_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrap_tracker #(.PTR_W(PTR_W), .SYNC_STAGES(STAGES)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_adv     (rd_adv),
        .wr_msb     (wr_msb),
        .rd_ptr     (rd_ptr),
        .sep_target (sep_target),
        .track_en   (track_en),
        .sample_vld (sample_vld),
        .sample_code(sample_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int rd, input int tg);
        int d;
        d = (rd - tg + NSLOT) % NSLOT;
        if (d == 0) return 0;
        if (d < NSLOT/2) return 1;
        return 2;
    endfunction

    // prefill chain with ones, then drop the bit and watch the strobe window
    task automatic run_event(input int rd, input int tg, input bit en, input int p,
                             input string req);
        int rise_hits;
        int hits;
        int hit_pos;
        int code_seen;
        int prev_code;
        int due;
        rd_ptr     = PTR_W'(rd);
        sep_target = PTR_W'(tg);
        track_en   = en;
        rd_adv     = 1'b1;
        wr_msb     = 1'b1;
        rise_hits  = 0;
        for (int i = 0; i < STAGES + 3; i++) begin
            @(negedge clk);
            if (sample_vld) rise_hits++;
        end
        // R4: rising edge on the sampled bit yields no strobe
        check(rise_hits == 0, "R4", rise_hits, 0);
        prev_code = int'(sample_code);
        wr_msb    = 1'b0;
        rd_adv    = 1'b1;
        hits      = 0;
        hit_pos   = -1;
        code_seen = -1;
        due       = (STAGES - 1) * p + 2;
        for (int j = 1; j <= due + 4; j++) begin
            @(negedge clk);
            rd_adv = ((j % p) == 0);
            if (sample_vld) begin
                hits++;
                hit_pos   = j;
                code_seen = int'(sample_code);
            end
        end
        rd_adv = 1'b1;
        if (en) begin
            // R3 / R2: one strobe, at the cycle set by the advancing edges
            check(hits == 1, "R3", hits, 1);
            check(hit_pos == due, "R2", hit_pos, due);
            check(code_seen == expect_code(rd, tg), req, code_seen, expect_code(rd, tg));
        end else begin
            // R8: suppressed strobe, verdict held
            check(hits == 0, "R8", hits, 0);
            check(int'(sample_code) == prev_code, "R8", int'(sample_code), prev_code);
        end
    endtask

    function automatic string req_of(input int rd, input int tg);
        int c;
        c = expect_code(rd, tg);
        if (c == 0) return "R5";
        if (c == 1) return "R6";
        return "R7";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: held in reset
        check(sample_vld == 1'b0, "R1", int'(sample_vld), 0);
        check(sample_code == 2'b00, "R1", int'(sample_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sample_vld == 1'b0, "R1", int'(sample_vld), 0);
        check(sample_code == 2'b00, "R1", int'(sample_code), 0);

        // full sweep of pointer/target pairs, no stalls
        for (int rd = 0; rd < NSLOT; rd++) begin
            for (int tg = 0; tg < NSLOT; tg++) begin
                run_event(rd, tg, 1'b1, 1, req_of(rd, tg));
            end
        end

        // stalled read advance: R2 timing under gaps
        for (int p = 2; p <= 3; p++) begin
            for (int tg = 0; tg < NSLOT; tg++) begin
                run_event((tg + 3 * p) % NSLOT, tg, 1'b1, p, req_of((tg + 3 * p) % NSLOT, tg));
            end
        end

        // R8: set a known verdict, then disable across several pairs
        run_event(1, 0, 1'b1, 1, "R6");
        run_event(0, 0, 1'b0, 1, "R8");
        run_event(5, 1, 1'b0, 2, "R8");
        run_event(4, 0, 1'b1, 1, "R7");
        run_event(2, 0, 1'b0, 1, "R8");

        // R4: rising only, after a long low level
        wr_msb = 1'b0;
        rd_adv = 1'b1;
        repeat (STAGES + 2) @(negedge clk);
        begin
            int hits;
            hits   = 0;
            wr_msb = 1'b1;
            for (int j = 0; j < STAGES + 6; j++) begin
                @(negedge clk);
                if (sample_vld) hits++;
            end
            check(hits == 0, "R4", hits, 0);
        end

        // R9: verdict is a legal code at the end
        check(sample_code != 2'b11, "R9", int'(sample_code), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule